// File: doc/BRIEF.md
# Grouped pin-change interrupt controller

This block watches up to twenty-four general-purpose input pins, arranged as three lanes of eight. Group 0 owns pins 7..0, group 1 owns pins 14..8 and group 2 owns pins 23..16. Pin 15 is not wired to any group. Every pin first passes through a two-stage synchroniser. A level change in either direction on a pin whose select bit is set raises the sticky flag of that pin's group.

Each group has an enable bit. A group drives its request line to the interrupt dispatcher only while three things hold: its flag is set, its enable is set and the global interrupt enable input is high. Software clears a flag by writing a one to it. The dispatcher also clears it by pulsing the group's acknowledge input when the vector is taken. If a new change arrives in the same cycle as a clear, the change wins and the flag stays set.

Software reaches the block through a small register port. A write takes effect on the next clock edge. A read returns data combinationally.

Top module: `pinchg_irq`

## Requirements
- R1: Group g samples pin_i[8g+7:8g]. Group 1 has only pins 14..8: pin_i[15] belongs to no group, and a change on it never sets a flag.
- R2: A rising or a falling level on a pin whose select bit is 1 sets its group's flag, read at address 0 bit g. A level applied just before clock edge k is visible in the flag after edge k+2 and not before.
- R3: A change on a pin whose select bit is 0 leaves every flag unchanged.
- R4: irq_o[g] is 1 exactly when flag g, enable bit g (address 1, bit g) and gie_i are all 1.
- R5: A write to address 0 clears each flag whose data bit is 1 and leaves flags whose data bit is 0 unchanged.
- R6: A one-cycle pulse on ack_i[g] clears flag g and no other flag.
- R7: When a masked change and a clear (a write-one or an acknowledge) meet in the same cycle, the flag ends set.
- R8: Flags are set by masked changes even while the group enable is 0.
- R9: Reserved bits read as zero: bits 7..3 at address 0, bits 7..3 at address 1, bit 7 at address 3, and the whole byte at addresses 5, 6 and 7.
- R10: After reset all flags, enables and select bits read 0 and irq_o is 0.
- R11: Register map: 0 holds the flags, 1 the group enables, and 2, 3, 4 the pin select bits of groups 0, 1, 2 (bit i selects pin 8g+i). A write is visible on the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 24 | Asynchronous pin levels, eight per group lane |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-group vector acknowledge, clears the flag |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, combinational |
| irq_o | output | 3 | Per-group interrupt request |

## Verification
On every cycle, the assertions check how requests are gated and how flags update. A request never appears without its flag and the global enable. A detected change always leaves its flag set on the next cycle, even when a clear arrives in that cycle. An acknowledge with no competing change clears its flag. A zero written to a flag bit keeps it. The reserved flag bits read zero. Only the bench scenarios can show the pin-to-group mapping, the exact synchroniser latency, the effect of the select bits, the ignored pin 15 and the read-back of the register map, because these depend on stimulus placed at chosen cycles.

// File: rtl/pinchg_pkg.sv
package pinchg_pkg;
    localparam int LANE_W = 8;
    localparam int NGRP   = 3;
    localparam int ADDR_W = 3;
    localparam int PIN_W  = NGRP * LANE_W;

    typedef enum logic [ADDR_W-1:0] {
        REG_FLAG  = 3'd0,
        REG_EN    = 3'd1,
        REG_MASK0 = 3'd2,
        REG_MASK1 = 3'd3,
        REG_MASK2 = 3'd4
    } reg_sel_e;

    typedef struct packed {
        logic mask_we;
        logic w1c;
        logic ack;
    } lane_ctl_t;

    function automatic logic [ADDR_W-1:0] mask_addr(int g);
        return ADDR_W'(int'(REG_MASK0) + g);
    endfunction
endpackage

// File: rtl/pinchg_sync.sv
module pinchg_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] chg_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [STAGES-1:0] sh;
        logic              prev;
        always_ff @(posedge clk) begin
            if (rst) begin
                sh   <= '0;
                prev <= 1'b0;
            end else begin
                sh   <= {sh[STAGES-2:0], d_i[i]};
                prev <= sh[STAGES-1];
            end
        end
        assign chg_o[i] = sh[STAGES-1] ^ prev;
    end
endmodule

// File: rtl/pinchg_lane.sv
module pinchg_lane
    import pinchg_pkg::*;
#(
    parameter logic [LANE_W-1:0] EXIST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANE_W-1:0] chg_i,
    input  lane_ctl_t         ctl_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] mask_o,
    output logic              flag_o,
    output logic              set_o
);
    logic [LANE_W-1:0] mask_q;
    logic              flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (ctl_i.mask_we)
            mask_q <= wdata_i & EXIST;
    end

    assign set_o = |(chg_i & mask_q & EXIST);

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else
            flag_q <= set_o | (flag_q & ~(ctl_i.w1c | ctl_i.ack));
    end

    assign mask_o = mask_q;
    assign flag_o = flag_q;
endmodule

// File: rtl/pinchg_regif.sv
module pinchg_regif
    import pinchg_pkg::*;
(
    input  logic                    wr_en_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [LANE_W-1:0]       wdata_i,
    input  logic [NGRP-1:0]         flag_i,
    input  logic [NGRP-1:0]         en_i,
    input  logic [PIN_W-1:0]        mask_i,
    output logic [NGRP-1:0]         mask_we_o,
    output logic [NGRP-1:0]         w1c_o,
    output logic                    en_we_o,
    output logic [LANE_W-1:0]       rdata_o
);
    logic [NGRP-1:0] hit_mask;

    for (genvar g = 0; g < NGRP; g++) begin : g_dec
        assign hit_mask[g]  = (addr_i == mask_addr(g));
        assign mask_we_o[g] = wr_en_i && hit_mask[g];
        assign w1c_o[g]     = wr_en_i && (addr_i == REG_FLAG) && wdata_i[g];
    end

    assign en_we_o = wr_en_i && (addr_i == REG_EN);

    always_comb begin
        rdata_o = '0;
        if (addr_i == REG_FLAG)
            rdata_o = {{(LANE_W-NGRP){1'b0}}, flag_i};
        else if (addr_i == REG_EN)
            rdata_o = {{(LANE_W-NGRP){1'b0}}, en_i};
        for (int g = 0; g < NGRP; g++)
            if (hit_mask[g])
                rdata_o = mask_i[g*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/pinchg_irq.sv
module pinchg_irq
    import pinchg_pkg::*;
#(
    parameter int              SYNC_STAGES = 2,
    parameter logic [PIN_W-1:0] PIN_EXIST  = 24'hFF_7F_FF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic              gie_i,
    input  logic [NGRP-1:0]   ack_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] rdata_o,
    output logic [NGRP-1:0]   irq_o
);
    logic [PIN_W-1:0] chg;
    logic [PIN_W-1:0] mask_q;
    logic [NGRP-1:0]  flag_q;
    logic [NGRP-1:0]  grp_set;
    logic [NGRP-1:0]  en_q;
    logic [NGRP-1:0]  mask_we;
    logic [NGRP-1:0]  w1c;
    logic             en_we;

    pinchg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_i   (pin_i),
        .chg_o (chg)
    );

    pinchg_regif u_regif (
        .wr_en_i   (wr_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .flag_i    (flag_q),
        .en_i      (en_q),
        .mask_i    (mask_q),
        .mask_we_o (mask_we),
        .w1c_o     (w1c),
        .en_we_o   (en_we),
        .rdata_o   (rdata_o)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_lane
        lane_ctl_t ctl;
        assign ctl = '{mask_we: mask_we[g], w1c: w1c[g], ack: ack_i[g]};
        pinchg_lane #(.EXIST(PIN_EXIST[g*LANE_W +: LANE_W])) u_lane (
            .clk     (clk),
            .rst     (rst),
            .chg_i   (chg[g*LANE_W +: LANE_W]),
            .ctl_i   (ctl),
            .wdata_i (wdata_i),
            .mask_o  (mask_q[g*LANE_W +: LANE_W]),
            .flag_o  (flag_q[g]),
            .set_o   (grp_set[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            en_q <= '0;
        else if (en_we)
            en_q <= wdata_i[NGRP-1:0];
    end

    assign irq_o = flag_q & en_q & {NGRP{gie_i}};
endmodule

// File: rtl/pinchg_irq_chk.sv
module pinchg_irq_chk
    import pinchg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              gie_i,
    input logic [NGRP-1:0]   ack_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [LANE_W-1:0] wdata_i,
    input logic [LANE_W-1:0] rdata_o,
    input logic [NGRP-1:0]   irq_o,
    input logic [NGRP-1:0]   grp_set,
    input logic [NGRP-1:0]   flag_q
);
    a_r10_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (flag_q == '0 && irq_o == '0));

    a_r4_no_irq_without_gie: assert property (@(posedge clk) disable iff (rst)
        !gie_i |-> irq_o == '0);

    a_r9_flag_reserved: assert property (@(posedge clk) disable iff (rst)
        (addr_i == REG_FLAG) |-> rdata_o[LANE_W-1:NGRP] == '0);

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
            irq_o[g] |-> flag_q[g]);

        a_r7_set_wins: assert property (@(posedge clk) disable iff (rst)
            grp_set[g] |=> flag_q[g]);

        a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
            (ack_i[g] && !grp_set[g]) |=> !flag_q[g]);

        a_r5_zero_write_keeps: assert property (@(posedge clk) disable iff (rst)
            (wr_en_i && addr_i == REG_FLAG && !wdata_i[g] && !ack_i[g] && flag_q[g])
            |=> flag_q[g]);
    end
endmodule

bind pinchg_irq pinchg_irq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .gie_i   (gie_i),
    .ack_i   (ack_i),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .grp_set (grp_set),
    .flag_q  (flag_q)
);

// File: tb/test_pinchg_irq.sv
`timescale 1ns/1ps
module test_pinchg_irq;
    import pinchg_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PIN_W-1:0]  pin_i = '0;
    logic              gie_i = 1'b0;
    logic [NGRP-1:0]   ack_i = '0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [LANE_W-1:0] wdata_i = '0;
    logic [LANE_W-1:0] rdata_o;
    logic [NGRP-1:0]   irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pinchg_irq i_pinchg_irq (
        .clk(clk), .rst(rst), .pin_i(pin_i), .gie_i(gie_i), .ack_i(ack_i),
        .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic flip(int p);
        @(negedge clk);
        pin_i[p] = ~pin_i[p];
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic ack_pulse(int g);
        @(negedge clk);
        ack_i[g] = 1'b1;
        @(negedge clk);
        ack_i = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 5; a++) begin
            rd(ADDR_W'(a), d);
            chk($sformatf("R10 reg %0d after reset", a), d, 8'h00);
        end
        chk("R10 irq after reset", {5'b0, irq_o}, 8'h00);
    endtask

    task automatic t_edges();
        logic [7:0] d;
        wr(REG_MASK0, 8'h01);
        wr(REG_MASK1, 8'h40);
        wr(REG_MASK2, 8'h80);
        flip(0);
        @(negedge clk); @(negedge clk);
        addr_i = REG_FLAG; #1;
        chk("R2 flag not yet set after two edges", rdata_o, 8'h00);
        @(negedge clk); #1;
        chk("R2 rising edge sets flag 0 after third edge", rdata_o, 8'h01);
        wr(REG_FLAG, 8'h01);
        flip(0); settle(); rd(REG_FLAG, d);
        chk("R2 falling edge sets flag 0", d, 8'h01);
        wr(REG_FLAG, 8'h01);
        flip(14); settle(); rd(REG_FLAG, d);
        chk("R1 pin 14 maps to group 1", d, 8'h02);
        wr(REG_FLAG, 8'h02);
        flip(23); settle(); rd(REG_FLAG, d);
        chk("R1 pin 23 maps to group 2", d, 8'h04);
        wr(REG_FLAG, 8'h07);
        rd(REG_FLAG, d);
        chk("R5 write ones clears all", d, 8'h00);
    endtask

    task automatic t_unmasked();
        logic [7:0] d;
        wr(REG_MASK1, 8'hFF);
        rd(REG_MASK1, d);
        chk("R9 group 1 select bit 7 reads zero", d, 8'h7F);
        flip(15); settle(); rd(REG_FLAG, d);
        chk("R1 pin 15 belongs to no group", d, 8'h00);
        wr(REG_MASK0, 8'hFE);
        flip(0); settle(); rd(REG_FLAG, d);
        chk("R3 deselected pin 0 ignored", d, 8'h00);
        flip(1); settle(); rd(REG_FLAG, d);
        chk("R3 selected pin 1 still detected", d, 8'h01);
        wr(REG_FLAG, 8'h01);
        wr(REG_MASK1, 8'h40);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        gie_i = 1'b1;
        wr(REG_EN, 8'h00);
        flip(1); settle(); rd(REG_FLAG, d);
        chk("R8 flag set with group disabled", d, 8'h01);
        chk("R4 no irq while group disabled", {5'b0, irq_o}, 8'h00);
        wr(REG_EN, 8'h01);
        #1 chk("R4 irq 0 with flag, enable, gie", {5'b0, irq_o}, 8'h01);
        gie_i = 1'b0;
        #1 chk("R4 irq dropped by gie low", {5'b0, irq_o}, 8'h00);
        gie_i = 1'b1;
        wr(REG_FLAG, 8'h01);
        #1 chk("R4 irq dropped after flag clear", {5'b0, irq_o}, 8'h00);
        wr(REG_EN, 8'h00);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        flip(1); flip(23); settle();
        rd(REG_FLAG, d);
        chk("R2 two groups flagged", d, 8'h05);
        wr(REG_FLAG, 8'h00);
        rd(REG_FLAG, d);
        chk("R5 zero write keeps flags", d, 8'h05);
        wr(REG_FLAG, 8'h04);
        rd(REG_FLAG, d);
        chk("R5 write one clears only group 2", d, 8'h01);
        wr(REG_FLAG, 8'h01);
        rd(REG_FLAG, d);
        chk("R5 write one clears group 0", d, 8'h00);
    endtask

    task automatic t_ack();
        logic [7:0] d;
        flip(1); flip(23); settle();
        ack_pulse(0);
        rd(REG_FLAG, d);
        chk("R6 ack 0 clears only group 0", d, 8'h04);
        ack_pulse(1);
        rd(REG_FLAG, d);
        chk("R6 ack 1 leaves group 2", d, 8'h04);
        ack_pulse(2);
        rd(REG_FLAG, d);
        chk("R6 ack 2 clears group 2", d, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        flip(1); settle();
        flip(1);
        @(negedge clk);
        wr(REG_FLAG, 8'h01);
        rd(REG_FLAG, d);
        chk("R7 change beats write-one clear", d, 8'h01);
        flip(1);
        @(negedge clk);
        ack_pulse(0);
        rd(REG_FLAG, d);
        chk("R7 change beats acknowledge", d, 8'h01);
        ack_pulse(0);
        rd(REG_FLAG, d);
        chk("R6 lone acknowledge clears", d, 8'h00);
    endtask

    task automatic t_map();
        logic [7:0] d;
        wr(REG_EN, 8'hFF);
        rd(REG_EN, d);
        chk("R9 enable reserved bits zero", d, 8'h07);
        wr(REG_MASK2, 8'hA5);
        rd(REG_MASK2, d);
        chk("R11 group 2 select read back", d, 8'hA5);
        rd(REG_MASK0, d);
        chk("R11 group 0 select unchanged", d, 8'hFE);
        wr(REG_FLAG, 8'hF8);
        rd(REG_FLAG, d);
        chk("R9 flag reserved bits zero", d, 8'h00);
        for (int a = 5; a < 8; a++) begin
            wr(ADDR_W'(a), 8'hFF);
            rd(ADDR_W'(a), d);
            chk($sformatf("R9 unmapped address %0d", a), d, 8'h00);
        end
        wr(REG_EN, 8'h00);
    endtask

    initial begin
        t_reset();
        t_edges();
        t_unmasked();
        t_irq();
        t_w1c();
        t_ack();
        t_collide();
        t_map();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule